// File: doc/BRIEF.md
# Multilevel Output Voltage Level Selector

This block is the current loop of a multilevel power converter controller. At every sample strobe it looks at a signed reference current, the measured output current and the full-scale current the converter can reach. From these it picks the voltage level, from 0 up to LEVELS-1, that the switch-state selector downstream must apply next.

The reference range from zero to full scale is cut into LEVELS-1 equal operating regions, numbered 1 to LEVELS-1. The region holding the reference sets the target level. If the measured current lags the reference, the target is the region number. If it overshoots, the target is one level lower. If the two are equal, the level stays as it was. Region thresholds come from multiplies and compares, so no divider is needed.

The chosen level is held as a token that sits in exactly one of LEVELS places, one place per level. The block also gives out the binary index of that place. When step limiting is on (the default), the token moves at most one place per sample, toward the target. This keeps every output transition between adjacent levels.

Top module: `mlvl_level_sel`

## Requirements
- R1: While reset is asserted, and after reset is released, the token sits in place 0: `token_o` = 1 and `level_o` = 0.
- R2: Exactly one bit of `token_o` is set at all times, and bit k is set exactly when `level_o` = k, where `level_o` is an unsigned binary level from 0 to LEVELS-1.
- R3: The outputs are registered. They can change only on the clock edge at which `sample_i` is high, and no input has any effect while `sample_i` is low.
- R4: The operating region is the j (from 1 to LEVELS-1) for which (j-1)·F < ref·(LEVELS-1) ≤ j·F, where F is `ifull_i`. A reference exactly on a boundary falls in the lower region. A reference at or below zero gives region 1, and a reference at or above F gives region LEVELS-1.
- R5: When the measured current is below the reference, the target level equals the operating region.
- R6: When the measured current equals the reference, a sample leaves the level unchanged.
- R7: When the measured current is above the reference, the target level equals the operating region minus one.
- R8: With STEP_LIMIT=1 (default), each sample moves the level one step toward the target, or leaves it in place if it is already there. The level never changes by more than one per sample. With STEP_LIMIT=0, the level jumps straight to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe; the loop advances on clock edges where it is high |
| iref_i | input | CUR_W | Reference current, signed fixed point |
| imeas_i | input | CUR_W | Measured output current, signed, same scale |
| ifull_i | input | CUR_W | Full-scale reachable current, signed, positive |
| level_o | output | $clog2(LEVELS) | Requested voltage level, unsigned binary |
| token_o | output | LEVELS | One-hot token, bit k for level k |

## Verification
Some properties hold at every clock and are checked that way: the token stays one-hot and agrees with the binary level, the outputs hold still between strobes, a sample with equal currents holds the level, and the level never moves by more than one step per sample. Other behaviour can only be shown by the bench's scenarios, which compare against expected levels. These cover where the region boundaries fall (including the exact-boundary and clamp cases), the region-or-region-minus-one choice, and the multi-sample climb toward a distant target.

// File: rtl/mlvl_pkg.sv
package mlvl_pkg;

  // three-way outcome of measured versus reference current
  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_RAISE = 2'd1,
    DIR_LOWER = 2'd2
  } dir_e;

  // target level chosen from region and direction
  function automatic int target_level(dir_e d, int region, int cur);
    int t;
    case (d)
      DIR_RAISE: t = region;
      DIR_LOWER: t = region - 1;
      default:   t = cur;
    endcase
    return t;
  endfunction

  // move one place toward the target
  function automatic int step_toward(int cur, int tgt);
    int n;
    if (tgt > cur)      n = cur + 1;
    else if (tgt < cur) n = cur - 1;
    else                n = cur;
    return n;
  endfunction

endpackage

// File: rtl/mlvl_region_lookup.sv
module mlvl_region_lookup #(
  parameter int LEVELS = 5,
  parameter int CUR_W  = 16,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic signed [CUR_W-1:0] iref_i,
  input  logic signed [CUR_W-1:0] ifull_i,
  output logic        [LVL_W-1:0] region_o
);
  localparam int NTHR  = LEVELS - 2;
  localparam int CNT_W = $clog2(LEVELS);
  localparam int PW    = CUR_W + CNT_W + 1;
  localparam logic signed [PW-1:0] SPAN = PW'(LEVELS - 1);

  logic signed [PW-1:0] ref_w;
  logic signed [PW-1:0] full_w;
  logic signed [PW-1:0] ref_scaled;
  logic [NTHR-1:0]      above;

  assign ref_w      = PW'(iref_i);
  assign full_w     = PW'(ifull_i);
  assign ref_scaled = ref_w * SPAN;

  // one compare per inner boundary; strict > keeps boundary values low
  for (genvar j = 0; j < NTHR; j++) begin : g_thr
    localparam logic signed [PW-1:0] MULT = PW'(j + 1);
    logic signed [PW-1:0] thr;
    assign thr      = full_w * MULT;
    assign above[j] = (ref_scaled > thr);
  end

  always_comb begin
    logic [LVL_W-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < NTHR; i++) cnt = cnt + LVL_W'(above[i]);
    region_o = cnt + LVL_W'(1);
  end

endmodule

// File: rtl/mlvl_direction_cmp.sv
module mlvl_direction_cmp #(
  parameter int CUR_W = 16
) (
  input  logic signed [CUR_W-1:0] iref_i,
  input  logic signed [CUR_W-1:0] imeas_i,
  output mlvl_pkg::dir_e          dir_o
);
  always_comb begin
    if (imeas_i < iref_i)      dir_o = mlvl_pkg::DIR_RAISE;
    else if (imeas_i > iref_i) dir_o = mlvl_pkg::DIR_LOWER;
    else                       dir_o = mlvl_pkg::DIR_HOLD;
  end
endmodule

// File: rtl/mlvl_level_token.sv
module mlvl_level_token #(
  parameter int LEVELS     = 5,
  parameter bit STEP_LIMIT = 1'b1,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  mlvl_pkg::dir_e     dir_i,
  input  logic [LVL_W-1:0]   region_i,
  output logic [LEVELS-1:0]  token_o,
  output logic [LVL_W-1:0]   level_o
);
  logic [LEVELS-1:0] token_q;
  logic [LEVELS-1:0] token_d;
  logic [LVL_W-1:0]  target;
  logic [LVL_W-1:0]  next_lvl;

  // binary index of the marked place
  always_comb begin
    level_o = '0;
    for (int k = 0; k < LEVELS; k++)
      if (token_q[k]) level_o = level_o | LVL_W'(k);
  end

  assign target = LVL_W'(mlvl_pkg::target_level(dir_i, int'(region_i), int'(level_o)));

  if (STEP_LIMIT) begin : g_step
    assign next_lvl = LVL_W'(mlvl_pkg::step_toward(int'(level_o), int'(target)));
  end else begin : g_jump
    assign next_lvl = target;
  end

  always_comb begin
    token_d = '0;
    token_d[next_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        token_q <= LEVELS'(1);
    else if (sample_i) token_q <= token_d;
  end

  assign token_o = token_q;

endmodule

// File: rtl/mlvl_level_sel.sv
module mlvl_level_sel #(
  parameter int LEVELS     = 5,
  parameter int CUR_W      = 16,
  parameter bit STEP_LIMIT = 1'b1,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_i,
  input  logic signed [CUR_W-1:0] iref_i,
  input  logic signed [CUR_W-1:0] imeas_i,
  input  logic signed [CUR_W-1:0] ifull_i,
  output logic [LVL_W-1:0]        level_o,
  output logic [LEVELS-1:0]       token_o
);
  logic [LVL_W-1:0] region_w;
  mlvl_pkg::dir_e   dir_w;

  mlvl_region_lookup #(.LEVELS(LEVELS), .CUR_W(CUR_W)) u_region (
    .iref_i   (iref_i),
    .ifull_i  (ifull_i),
    .region_o (region_w)
  );

  mlvl_direction_cmp #(.CUR_W(CUR_W)) u_dir (
    .iref_i  (iref_i),
    .imeas_i (imeas_i),
    .dir_o   (dir_w)
  );

  mlvl_level_token #(.LEVELS(LEVELS), .STEP_LIMIT(STEP_LIMIT)) u_token (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_i),
    .dir_i    (dir_w),
    .region_i (region_w),
    .token_o  (token_o),
    .level_o  (level_o)
  );

endmodule

// File: rtl/mlvl_level_sel_chk.sv
module mlvl_level_sel_chk #(
  parameter int LEVELS     = 5,
  parameter int CUR_W      = 16,
  parameter bit STEP_LIMIT = 1'b1,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_i,
  input logic signed [CUR_W-1:0] iref_i,
  input logic signed [CUR_W-1:0] imeas_i,
  input logic [LVL_W-1:0]        level_o,
  input logic [LEVELS-1:0]       token_o
);
  // R2
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(token_o) == 1);

  // R2
  token_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_o[level_o] == 1'b1);

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(token_o));

  // R6
  equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && (iref_i == imeas_i)) |=> $stable(level_o));

  if (STEP_LIMIT) begin : g_step_chk
    // R8
    adjacent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_i |=> ((level_o == $past(level_o)) ||
                    (level_o == $past(level_o) + LVL_W'(1)) ||
                    (level_o + LVL_W'(1) == $past(level_o))));
  end

endmodule

bind mlvl_level_sel mlvl_level_sel_chk #(
  .LEVELS(LEVELS), .CUR_W(CUR_W), .STEP_LIMIT(STEP_LIMIT)
) u_chk (.*);

// File: tb/mlvl_level_sel_bench.sv
module mlvl_level_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 5;
  localparam int CUR_W  = 16;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int NVEC   = 20;

  // ref, meas, expected level, requirement tag (4=R4,5=R5,6=R6,7=R7,8=R8)
  localparam int VEC [NVEC][4] = '{
    '{ 600,    0, 1, 8}, '{ 600,    0, 2, 8}, '{ 600,    0, 3, 5}, '{ 600,    0, 3, 5},
    '{ 600,  700, 2, 7}, '{ 600,  600, 2, 6}, '{ 250,    0, 1, 4}, '{ 251,    0, 2, 4},
    '{ -50, -100, 1, 4}, '{ -50,    0, 0, 7}, '{2000,    0, 1, 8}, '{2000,    0, 2, 8},
    '{2000,    0, 3, 8}, '{2000,    0, 4, 4}, '{2000,    0, 4, 5}, '{1000, 1200, 3, 7},
    '{ 750,  800, 2, 4}, '{ 751,  751, 2, 6}, '{ 751,    0, 3, 8}, '{   0,    0, 3, 6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b0;
  logic signed [CUR_W-1:0] iref_i = '0;
  logic signed [CUR_W-1:0] imeas_i = '0;
  logic signed [CUR_W-1:0] ifull_i = 16'sd1000;
  logic [LVL_W-1:0] level_o;
  logic [LEVELS-1:0] token_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlvl_level_sel u_mlvl_level_sel (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .iref_i(iref_i), .imeas_i(imeas_i), .ifull_i(ifull_i),
    .level_o(level_o), .token_o(token_o)
  );

  function automatic string tag_name(int t);
    case (t)
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // level plus token consistency (R2)
  task automatic check_level(string req, int exp);
    check(req, int'(level_o), exp);
    check("R2", int'(token_o), 1 << exp);
  endtask

  task automatic apply(int r, int m);
    @(negedge clk);
    iref_i = CUR_W'(r);
    imeas_i = CUR_W'(m);
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  initial begin
    // R1: reset state while held
    #(CLK_PERIOD*2);
    check("R1", int'(level_o), 0);
    check("R1", int'(token_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(level_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][0], VEC[i][1]);
      check_level(tag_name(VEC[i][3]), VEC[i][2]);
    end

    // R3: inputs that would move the level, but no strobe
    iref_i = 16'sd2000;
    imeas_i = 16'sd0;
    repeat (4) @(negedge clk);
    check_level("R3", 3);

    // R4: reference far above full scale clamps to top region
    apply(30000, 0);
    check_level("R4", 4);
    // R7 at top: region 4 minus one
    apply(30000, 31000);
    check_level("R7", 3);

    // R1: mid-run reset returns the token to place 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_level("R1", 0);
    rst_n = 1'b1;
    apply(-5000, -6000);
    check_level("R4", 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule